// File: doc/BRIEF.md
# Serial EEPROM Command Guard with Ready/Busy Status

This block is the front end of a three-wire serial EEPROM slave: select (`cs_i`), serial clock (`sck_i`) and data in (`di_i`), plus a data output with an enable. All three inputs are sampled in the system clock domain. A frame begins when the first 1 is seen on `di_i` at a rising serial clock edge. The block then collects a two-bit opcode, `ADDR_W` address bits and `DATA_W` data bits. It also counts every serial clock rising edge from the start bit until select drops.

When select falls, the command is checked against its expected length. A write, an erase, a write-all or an erase-all is committed only if the count equals that length exactly. A frame with a glitch clock, or one that is missing a clock, is dropped without any indication. A commit raises a one-cycle strobe that carries the command, address and data in place of a memory array. The commit also starts an internal write cycle that lasts `WR_CYCLES` system clocks.

While the write cycle runs, the data output reports busy (0) whenever select is high, after a settling delay of `STATUS_DLY` clocks. When the cycle ends, it reports ready (1). Ready is withdrawn when select drops or when a new start bit is decoded.

Top module: `sguard_top`

## Requirements
- R1: Zeros on `di_i` at serial clock rises before the first 1 are ignored and are not counted. The first 1 is the start bit and counts as clock 1 of the frame.
- R2: Opcode bits 0 then 1 after the start bit select a write. With exactly 3+ADDR_W+DATA_W clocks it commits with `commit_cmd_o`=0 and the address and data sent MSB first. `commit_o` rises one clock after select is seen low.
- R3: Opcode 1,1 selects an erase. With exactly 3+ADDR_W clocks it commits with `commit_cmd_o`=1 and the address sent.
- R4: Opcode 0,0 uses the two top address bits as an extension. Extension 01 is write-all, needs 3+ADDR_W+DATA_W clocks and gives `commit_cmd_o`=2. Extension 10 is erase-all, needs 3+ADDR_W clocks and gives `commit_cmd_o`=3. Extensions 00 and 11 never commit, and neither does opcode 1,0.
- R5: A frame whose clock count differs from the expected length never commits. This covers one or two extra clocks and one or two missing clocks.
- R6: Each accepted frame produces exactly one clock of `commit_o` high.
- R7: After a commit the block is busy for `WR_CYCLES` clocks. While busy and select is high past the settling delay, `do_oe_o`=1 and `do_o`=0.
- R8: While busy, the serial input is ignored. A complete valid frame clocked in during the busy period does not commit.
- R9: After the busy period, with select high past the settling delay, `do_oe_o`=1 and `do_o`=1. This ready report ends when a start bit is decoded or when select goes low, and later selects then show nothing.
- R10: `do_oe_o` is 0 while select is low. After select rises it stays 0 for the first `STATUS_DLY` clocks and can rise after the clock that follows them.
- R11: During reset `commit_o`, `do_o` and `do_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Select, active high |
| sck_i | input | 1 | Serial clock, sampled by `clk` |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Status output: 0 busy, 1 ready |
| do_oe_o | output | 1 | Output enable for `do_o` (high-impedance when 0) |
| commit_o | output | 1 | One-clock strobe for an accepted modifying command |
| commit_cmd_o | output | 2 | Command: 0 write, 1 erase, 2 write-all, 3 erase-all |
| commit_addr_o | output | ADDR_W | Address of the committed command |
| commit_data_o | output | DATA_W | Data of the committed command |

## Verification
Write frames are sent with a sweep of address and data values, so a swapped or shifted field shows up as a wrong value. Every pairing of opcode, extension bits and short or long frame length is also tried. This separates the four committing commands from the look-alikes that must stay silent. Frames from two clocks short to two clocks long, and frames with leading zeros, show whether the count is exact and whether it starts at the start bit. A select session held open across the write cycle checks several things: the settling window, busy and then ready on the output, a full frame ignored while busy, and the ready report withdrawn after a start bit or after deselect.

// File: rtl/sguard_pkg.sv
package sguard_pkg;
  typedef enum logic [1:0] {
    CMD_WRITE = 2'd0,
    CMD_ERASE = 2'd1,
    CMD_WRAL  = 2'd2,
    CMD_ERAL  = 2'd3
  } cmd_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_WRAL  = 2'b01;
  localparam logic [1:0] EXT_ERAL  = 2'b10;
endpackage

// File: rtl/sguard_rx.sv
module sguard_rx #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int CW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              sck_rise,
  input  logic              di_i,
  input  logic              busy,
  output logic              started,
  output logic [CW-1:0]     cnt,
  output logic [1:0]        op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              start_pulse
);
  localparam int OPC_END = 2;
  localparam int ADR_END = 2 + ADDR_W;
  localparam int DAT_END = 2 + ADDR_W + DATA_W;
  localparam int CNT_SAT = DAT_END + 2;

  logic take;
  assign take        = sck_rise && cs_i && !busy;
  assign start_pulse = take && !started && di_i;

  always_ff @(posedge clk) begin
    if (rst || !cs_i) begin
      started <= 1'b0;
      cnt     <= '0;
      op      <= '0;
      addr    <= '0;
      data    <= '0;
    end else if (take) begin
      if (!started) begin
        if (di_i) begin
          started <= 1'b1;
          cnt     <= CW'(1);
        end
      end else begin
        if (cnt <= CW'(OPC_END))
          op <= {op[0], di_i};
        else if (cnt <= CW'(ADR_END))
          addr <= {addr[ADDR_W-2:0], di_i};
        else if (cnt <= CW'(DAT_END))
          data <= {data[DATA_W-2:0], di_i};
        if (cnt != CW'(CNT_SAT))
          cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sguard_check.sv
module sguard_check
  import sguard_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int CW     = 5
) (
  input  logic              started,
  input  logic [CW-1:0]     cnt,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output logic              ok,
  output cmd_e              cmd
);
  localparam int LEN_LONG  = 3 + ADDR_W + DATA_W;
  localparam int LEN_SHORT = 3 + ADDR_W;

  logic          modifying;
  logic [CW-1:0] want;

  always_comb begin
    modifying = 1'b0;
    want      = '0;
    cmd       = CMD_WRITE;
    case (op)
      OPC_WRITE: begin
        modifying = 1'b1; want = CW'(LEN_LONG);  cmd = CMD_WRITE;
      end
      OPC_ERASE: begin
        modifying = 1'b1; want = CW'(LEN_SHORT); cmd = CMD_ERASE;
      end
      OPC_EXT: begin
        if (addr[ADDR_W-1 -: 2] == EXT_WRAL) begin
          modifying = 1'b1; want = CW'(LEN_LONG);  cmd = CMD_WRAL;
        end else if (addr[ADDR_W-1 -: 2] == EXT_ERAL) begin
          modifying = 1'b1; want = CW'(LEN_SHORT); cmd = CMD_ERAL;
        end
      end
      default: modifying = 1'b0;
    endcase
    ok = started && modifying && (cnt == want);
  end
endmodule

// File: rtl/sguard_status.sv
module sguard_status #(
  parameter int WR_CYCLES  = 40,
  parameter int STATUS_DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic cs_fall,
  input  logic commit,
  input  logic start_pulse,
  output logic busy,
  output logic do_o,
  output logic do_oe_o
);
  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam int SW = $clog2(STATUS_DLY + 1);

  logic [TW-1:0] tmr;
  logic [SW-1:0] sel;
  logic          armed;
  logic          settled;

  assign settled = cs_i && (sel == SW'(STATUS_DLY));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (commit) begin
      busy <= 1'b1;
      tmr  <= TW'(WR_CYCLES - 1);
    end else if (busy) begin
      if (tmr == '0) busy <= 1'b0;
      else           tmr  <= tmr - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_i)                sel <= '0;
    else if (sel != SW'(STATUS_DLY)) sel <= sel + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                                 armed <= 1'b0;
    else if (commit)                         armed <= 1'b1;
    else if (start_pulse || (cs_fall && !busy)) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      do_oe_o <= 1'b0;
      do_o    <= 1'b0;
    end else begin
      do_oe_o <= settled && (busy || armed);
      do_o    <= settled && !busy && armed;
    end
  end
endmodule

// File: rtl/sguard_top.sv
module sguard_top
  import sguard_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int WR_CYCLES  = 40,
  parameter int STATUS_DLY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              sck_i,
  input  logic              di_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              commit_o,
  output logic [1:0]        commit_cmd_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o
);
  localparam int CW = $clog2(3 + ADDR_W + DATA_W + 2);

  logic              cs_q, sck_q;
  logic              sck_rise, cs_fall, commit_now;
  logic              busy_w, rx_started, start_pulse, ok;
  logic [CW-1:0]     rx_cnt;
  logic [1:0]        rx_op;
  logic [ADDR_W-1:0] rx_addr;
  logic [DATA_W-1:0] rx_data;
  cmd_e              cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_i;
      sck_q <= sck_i;
    end
  end

  assign sck_rise   = sck_i && !sck_q;
  assign cs_fall    = cs_q && !cs_i;
  assign commit_now = cs_fall && !busy_w && ok;

  sguard_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW)) rx_i (
    .clk(clk), .rst(rst), .cs_i(cs_i), .sck_rise(sck_rise), .di_i(di_i),
    .busy(busy_w), .started(rx_started), .cnt(rx_cnt), .op(rx_op),
    .addr(rx_addr), .data(rx_data), .start_pulse(start_pulse)
  );

  sguard_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW)) chk_i (
    .started(rx_started), .cnt(rx_cnt), .op(rx_op), .addr(rx_addr),
    .ok(ok), .cmd(cmd)
  );

  sguard_status #(.WR_CYCLES(WR_CYCLES), .STATUS_DLY(STATUS_DLY)) st_i (
    .clk(clk), .rst(rst), .cs_i(cs_i), .cs_fall(cs_fall), .commit(commit_now),
    .start_pulse(start_pulse), .busy(busy_w), .do_o(do_o), .do_oe_o(do_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_o      <= 1'b0;
      commit_cmd_o  <= '0;
      commit_addr_o <= '0;
      commit_data_o <= '0;
    end else begin
      commit_o <= commit_now;
      if (commit_now) begin
        commit_cmd_o  <= cmd;
        commit_addr_o <= rx_addr;
        commit_data_o <= rx_data;
      end
    end
  end
endmodule

// File: rtl/sguard_sva.sv
module sguard_sva (
  input logic clk,
  input logic rst,
  input logic cs_i,
  input logic commit_o,
  input logic do_o,
  input logic do_oe_o,
  input logic busy,
  input logic frame_started
);
  // R6: strobe lasts a single clock
  p_commit_single_r6: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  // R2: commit only follows select seen high then low
  p_commit_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (!$past(cs_i) && $past(cs_i, 2)));

  // R7: busy period always begins with a commit
  p_busy_from_commit_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> commit_o);

  // R7: status while busy is 0
  p_busy_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (do_oe_o && $past(busy)) |-> !do_o);

  // R8: no frame is collected while busy
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !frame_started);

  // R10: output enabled only when select was high
  p_oe_needs_cs_r10: assert property (@(posedge clk) disable iff (rst)
    do_oe_o |-> $past(cs_i));
endmodule

bind sguard_top sguard_sva sva_i (
  .clk(clk), .rst(rst), .cs_i(cs_i), .commit_o(commit_o), .do_o(do_o),
  .do_oe_o(do_oe_o), .busy(busy_w), .frame_started(rx_started)
);

// File: tb/sguard_top_tb_top.sv
`timescale 1ns/1ps
module sguard_top_tb_top;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int WR    = 200;
  localparam int DLY   = 4;
  localparam int LONG  = 3 + AW + DW;
  localparam int SHORT = 3 + AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cs, sck, di;
  logic do_o, do_oe_o, commit_o;
  logic [1:0]    commit_cmd_o;
  logic [AW-1:0] commit_addr_o;
  logic [DW-1:0] commit_data_o;

  sguard_top #(.ADDR_W(AW), .DATA_W(DW), .WR_CYCLES(WR), .STATUS_DLY(DLY)) dut_i (
    .clk(clk), .rst(rst), .cs_i(cs), .sck_i(sck), .di_i(di),
    .do_o(do_o), .do_oe_o(do_oe_o), .commit_o(commit_o),
    .commit_cmd_o(commit_cmd_o), .commit_addr_o(commit_addr_o),
    .commit_data_o(commit_data_o)
  );

  int checks = 0, errors = 0, ncommit = 0;
  int lcmd = 0, laddr = 0, ldata = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (!rst && commit_o) begin
      ncommit++;
      lcmd  = int'(commit_cmd_o);
      laddr = int'(commit_addr_o);
      ldata = int'(commit_data_o);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input bit b);
    di = b; sck = 1'b1; tick(2);
    sck = 1'b0; tick(2);
  endtask

  task automatic frame(input logic [63:0] v, input int n);
    cs = 1'b1; tick(2);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    tick(2); cs = 1'b0; di = 1'b0; tick(2);
  endtask

  function automatic logic [63:0] mk(input int op, input int a, input int d, input bit lng);
    logic [63:0] v;
    v = 64'd1;
    v = (v << 2) | 64'(op & 3);
    v = (v << AW) | 64'(a & ((1 << AW) - 1));
    if (lng) v = (v << DW) | 64'(d & ((1 << DW) - 1));
    return v;
  endfunction

  task automatic run(input logic [63:0] v, input int n, input int ec, input int ecmd,
                     input int ea, input int ed, input bit dchk, input string req);
    int c0;
    c0 = ncommit;
    frame(v, n);
    chk(req, ncommit - c0, ec);
    if (ec != 0) begin
      chk(req, lcmd, ecmd);
      chk(req, laddr, ea);
      if (dchk) chk(req, ldata, ed);
    end
    tick(WR + 10);
  endtask

  initial begin
    #900000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs = 1'b0; sck = 1'b0; di = 1'b0;
    tick(5);
    chk("R11 commit", int'(commit_o), 0);
    chk("R11 oe", int'(do_oe_o), 0);
    chk("R11 do", int'(do_o), 0);
    rst = 1'b0; tick(3);

    // R2: write sweep over address and data
    for (int k = 0; k < 6; k++) begin
      int a, d;
      a = (k * 11 + 3) % (1 << AW);
      d = (k * 37 + 5) % (1 << DW);
      run(mk(1, a, d, 1), LONG, 1, 0, a, d, 1, "R2 write");
    end

    // R1: leading zeros ignored, zeros alone start nothing
    run(mk(1, 21, 8'hA5, 1), LONG + 3, 1, 0, 21, 8'hA5, 1, "R1 leading zeros");
    run(64'd0, 12, 0, 0, 0, 0, 0, "R1 zeros only");

    // R3: erase
    for (int k = 0; k < 3; k++) begin
      int a;
      a = (k * 19 + 7) % (1 << AW);
      run(mk(3, a, 0, 0), SHORT, 1, 1, a, 0, 0, "R3 erase");
    end

    // R4: every opcode, extension and length
    for (int op = 0; op < 4; op++)
      for (int ext = 0; ext < 4; ext++)
        for (int lg = 0; lg < 2; lg++) begin
          int a, ec, ecmd;
          a = (ext << (AW - 2)) | 5;
          ec = 0; ecmd = 0;
          if (op == 1 && lg == 1)                  begin ec = 1; ecmd = 0; end
          if (op == 3 && lg == 0)                  begin ec = 1; ecmd = 1; end
          if (op == 0 && ext == 1 && lg == 1)      begin ec = 1; ecmd = 2; end
          if (op == 0 && ext == 2 && lg == 0)      begin ec = 1; ecmd = 3; end
          run(mk(op, a, 8'h3C, lg[0]), lg ? LONG : SHORT, ec, ecmd, a, 8'h3C,
              lg[0], "R4 opcode sweep");
        end

    // R5: wrong counts, extra and missing clocks
    for (int off = -2; off <= 2; off++) begin
      if (off != 0) begin
        logic [63:0] vw, ve;
        vw = mk(1, 9, 8'h5A, 1);
        ve = mk(3, 9, 0, 0);
        if (off > 0) begin vw = vw << off; ve = ve << off; end
        else begin vw = vw >> (-off); ve = ve >> (-off); end
        run(vw, LONG + off, 0, 0, 0, 0, 0, "R5 write length");
        run(ve, SHORT + off, 0, 0, 0, 0, 0, "R5 erase length");
      end
    end

    // R7, R8, R10: status while busy, frame ignored
    begin
      int c0;
      c0 = ncommit;
      frame(mk(1, 12, 8'h77, 1), LONG);
      chk("R6 single strobe", ncommit - c0, 1);
      cs = 1'b1; tick(DLY);
      chk("R10 settle oe", int'(do_oe_o), 0);
      tick(1);
      chk("R7 busy oe", int'(do_oe_o), 1);
      tick(1);
      chk("R7 busy do", int'(do_o), 0);
      c0 = ncommit;
      begin
        logic [63:0] v;
        v = mk(1, 30, 8'h81, 1);
        for (int i = LONG - 1; i >= 0; i--) sbit(v[i]);
      end
      cs = 1'b0; di = 1'b0; tick(2);
      chk("R8 ignored while busy", ncommit - c0, 0);
      chk("R10 oe low deselected", int'(do_oe_o), 0);
      cs = 1'b1; tick(DLY + 2);
      chk("R7 still busy oe", int'(do_oe_o), 1);
      chk("R7 still busy do", int'(do_o), 0);
      tick(WR);
      chk("R9 ready oe", int'(do_oe_o), 1);
      chk("R9 ready do", int'(do_o), 1);
      sbit(1'b1); tick(2);
      chk("R9 start clears ready", int'(do_oe_o), 0);
      cs = 1'b0; di = 1'b0; tick(3);
      chk("R9 no stray commit", ncommit - c0, 0);
    end

    // R9: ready survives a deselect during busy, cleared by deselect after
    run(mk(1, 44, 8'h19, 1), LONG, 1, 0, 44, 8'h19, 1, "R2 write");
    cs = 1'b1; tick(DLY + 2);
    chk("R9 ready after busy oe", int'(do_oe_o), 1);
    chk("R9 ready after busy do", int'(do_o), 1);
    cs = 1'b0; tick(2);
    chk("R10 oe low after deselect", int'(do_oe_o), 0);
    cs = 1'b1; tick(DLY + 2);
    chk("R9 ready withdrawn", int'(do_oe_o), 0);
    cs = 1'b0; tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end
endmodule